// File: doc/BRIEF.md
# Ripple-reducing PWM D/A generator

This block produces two pulse-width modulated outputs. Each output, once smoothed by an external low-pass filter, acts as a D/A converter whose resolution equals the counter width (14 bits by default). One counter is shared by both channels. A clock prescaler advances the counter once every T system clocks, and T can be chosen from eight values. Each channel compares the counter against its own data word to form its output.

The block does not emit one long pulse per conversion period. It splits the period into many short base cycles, each 64·T or 256·T long, and each channel chooses its own length. Every base cycle carries the same coarse high time. Single extra T-wide pulses supply the fine bits. They are placed in a bit-reversed order of the base-cycle index, so they are spread across the period and the ripple after filtering is small.

Software reaches the block through a write-only register port with three words: a control word and one data word per channel. A new data word takes effect only at the next period boundary.

Top module: `pwm_dac_gen`

## Requirements
- R1: After reset both outputs are low, the control word is zero (stopped) and both data words are zero.
- R2: A write with `wr_addr`=0 loads the control word from `wr_data[5:0]`. Bits [2:0] select the prescaler, bit 3 is the run bit, bit 4 enables channel A and bit 5 enables channel B. `wr_addr`=1 writes the data word of A and `wr_addr`=2 writes the data word of B. In a data word, bit 0 selects the base cycle (0 = 64·T, 1 = 256·T) and bits [CW:1] hold the value V.
- R3: Prescaler select 0..7 gives T = 1, 2, 64, 128, 256, 1024, 4096 and 16384 clocks per counter step.
- R4: Over one full period of 2^CW·T clocks, a running and enabled channel is high for exactly V·T clocks, in either base-cycle mode.
- R5: In 64·T mode the coarse value C is the upper 6 bits of V and the fine value F is the lower CW-6 bits. There are 2^(CW-6) base cycles, and base cycle i (counted from the period start) is high for (C+x)·T clocks.
- R6: In 256·T mode C is the upper 8 bits of V and F is the lower CW-8 bits. There are 2^(CW-8) base cycles, and base cycle i is high for (C+x)·T clocks.
- R7: In either mode x is 1 exactly when the bit-reversed index of base cycle i, taken over the index width, is less than F. The high time of a base cycle starts at the beginning of that base cycle.
- R8: A data write made while the block runs leaves the current period unchanged and takes effect from the next period.
- R9: An output stays low while its channel enable bit is clear, and the other channel is not affected.
- R10: While the run bit is clear the counter is held at zero and both outputs are low. Setting the run bit starts a period, and the first counter state reaches the outputs one clock after the control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 data A, 2 data B |
| wr_data | input | CW+1 | Write data |
| pwm_a | output | 1 | Channel A PWM output |
| pwm_b | output | 1 | Channel B PWM output |

## Verification
The bench builds the block with CW=10, which gives a 1024-step period. At that size whole periods at T=1 and T=2 can be checked base cycle by base cycle, with many random values and both base-cycle modes, within the run budget. Every prescaler setting up to T=16384 is checked by timing the single T-wide pulse that coarse value 1 produces. The period-boundary update is checked by writing a new value just after start and then measuring the first two consecutive periods.

// File: rtl/pwm_dac_gen.sv
module pwm_dac_gen #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW:0]   wr_data,
  output logic          pwm_a,
  output logic          pwm_b
);
  localparam int PW = 14;

  logic [5:0]    ctrl;
  logic [CW:0]   data_a, data_b, act_a, act_b;
  logic [CW-1:0] cnt;
  logic [PW-1:0] div_cnt, div_max;

  wire run  = ctrl[3];
  wire tick = run && (div_cnt >= div_max);
  wire wrap = tick && (cnt == '1);

  always_comb begin
    case (ctrl[2:0])
      3'd0:    div_max = PW'(0);
      3'd1:    div_max = PW'(1);
      3'd2:    div_max = PW'(63);
      3'd3:    div_max = PW'(127);
      3'd4:    div_max = PW'(255);
      3'd5:    div_max = PW'(1023);
      3'd6:    div_max = PW'(4095);
      default: div_max = PW'(16383);
    endcase
  end

  function automatic logic level(input logic [CW:0] d, input logic [CW-1:0] c);
    logic [CW-1:0] v;
    logic [CW-7:0] r6;
    logic [CW-9:0] r8;
    v = d[CW:1];
    for (int i = 0; i < CW - 6; i++) r6[i] = c[CW-1-i];
    for (int i = 0; i < CW - 8; i++) r8[i] = c[CW-1-i];
    if (d[0])
      level = (c[7:0] < v[CW-1:CW-8]) ||
              ((c[7:0] == v[CW-1:CW-8]) && (r8 < v[CW-9:0]));
    else
      level = (c[5:0] < v[CW-1:CW-6]) ||
              ((c[5:0] == v[CW-1:CW-6]) && (r6 < v[CW-7:0]));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      data_a  <= '0;
      data_b  <= '0;
      act_a   <= '0;
      act_b   <= '0;
      cnt     <= '0;
      div_cnt <= '0;
      pwm_a   <= 1'b0;
      pwm_b   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0:    ctrl   <= wr_data[5:0];
          2'd1:    data_a <= wr_data;
          2'd2:    data_b <= wr_data;
          default: ;
        endcase
      end
      if (!run) begin
        cnt     <= '0;
        div_cnt <= '0;
      end else if (tick) begin
        cnt     <= cnt + 1'b1;
        div_cnt <= '0;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
      if (!run || wrap) begin
        act_a <= data_a;
        act_b <= data_b;
      end
      pwm_a <= run && ctrl[4] && level(act_a, cnt);
      pwm_b <= run && ctrl[5] && level(act_b, cnt);
    end
  end

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !pwm_a && !pwm_b)); // R10
  AST_EN_A_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[4] |=> !pwm_a); // R9
  AST_EN_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[5] |=> !pwm_b); // R9
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt)); // R3
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(act_a) && $stable(act_b))); // R8
endmodule

// File: tb/tb_pwm_dac_gen.sv
module tb_pwm_dac_gen;
  localparam int CW = 10;
  localparam int P  = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [CW:0] wr_data = '0;
  logic pwm_a, pwm_b;
  int nchk = 0, nerr = 0;
  bit done = 0;

  pwm_dac_gen #(.CW(CW)) dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                              .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b));

  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tval(int sel);
    int t[8] = '{1, 2, 64, 128, 256, 1024, 4096, 16384};
    return t[sel];
  endfunction

  function automatic int exp_base(int v, bit m, int i, int t);
    int nf = CW - (m ? 8 : 6);
    int c = v >> nf, f = v & ((1 << nf) - 1), r = 0;
    for (int b = 0; b < nf; b++) if ((i >> b) & 1) r |= 1 << (nf - 1 - b);
    return (c + ((r < f) ? 1 : 0)) * t;
  endfunction

  task automatic wr(logic [1:0] a, logic [CW:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic setup(int sel, int va, bit ma, int vb, bit mb, bit ea, bit eb);
    wr(2'd0, '0);
    wr(2'd1, {CW'(va), ma});
    wr(2'd2, {CW'(vb), mb});
    wr(2'd0, (CW+1)'({eb, ea, 1'b1, 3'(sel)}));
  endtask

  task automatic measure(int t, int va, bit ma, int vb, bit mb, bit ea, bit eb,
                         string req, bit dow, int nv);
    int sa[256], sb[256];
    int ta = 0, tb = 0;
    int la = (ma ? 256 : 64) * t, lb = (mb ? 256 : 64) * t;
    foreach (sa[k]) begin sa[k] = 0; sb[k] = 0; end
    for (int s = 0; s < P * t; s++) begin
      @(negedge clk);
      if (pwm_a) begin sa[s / la]++; ta++; end
      if (pwm_b) begin sb[s / lb]++; tb++; end
      if (dow && s == 0) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = {CW'(nv), ma}; end
      if (dow && s == 1) wr_en = 1'b0;
    end
    check({req, " total A"}, ta, ea ? va * t : 0);
    check({req, " total B"}, tb, eb ? vb * t : 0);
    if (ea) for (int i = 0; i < P * t / la; i++)
      check({req, ma ? " R6 R7 base A" : " R5 R7 base A"}, sa[i], exp_base(va, ma, i, t));
    if (eb) for (int i = 0; i < P * t / lb; i++)
      check({req, mb ? " R6 R7 base B" : " R5 R7 base B"}, sb[i], exp_base(vb, mb, i, t));
  endtask

  initial begin
    #(10 * 190000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    int hi;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hi = 0;
    for (int s = 0; s < 20; s++) begin @(negedge clk); hi += int'(pwm_a) + int'(pwm_b); end
    check("R1 outputs low after reset", hi, 0);

    setup(0, 0, 0, P - 1, 1, 1, 1);   measure(1, 0, 0, P - 1, 1, 1, 1, "R4 R2 zero/max", 0, 0);
    setup(0, P - 1, 0, 0, 1, 1, 1);   measure(1, P - 1, 0, 0, 1, 1, 1, "R4 max/zero", 0, 0);
    setup(0, 1, 1, 1, 0, 1, 1);       measure(1, 1, 1, 1, 0, 1, 1, "R4 R7 single fine", 0, 0);
    setup(1, 37, 0, 613, 1, 1, 1);    measure(2, 37, 0, 613, 1, 1, 1, "R3 R4 T=2", 0, 0);

    setup(0, 300, 0, 5, 1, 1, 1);
    measure(1, 300, 0, 5, 1, 1, 1, "R8 old value kept", 1, 700);
    measure(1, 700, 0, 5, 1, 1, 1, "R8 new value at boundary", 0, 0);

    setup(0, 500, 0, 222, 1, 0, 1);   measure(1, 500, 0, 222, 1, 0, 1, "R9 A disabled", 0, 0);
    setup(0, 500, 1, 222, 0, 1, 0);   measure(1, 500, 1, 222, 0, 1, 0, "R9 B disabled", 0, 0);

    for (int it = 0; it < 10; it++) begin
      int t = ($urandom % 2) + 1;
      int va = $urandom % P, vb = $urandom % P;
      bit ma = 1'($urandom), mb = 1'($urandom);
      setup(t - 1, va, ma, vb, mb, 1, 1);
      measure(t, va, ma, vb, mb, 1, 1, "R4 random", 0, 0);
    end

    setup(0, 800, 0, 800, 1, 1, 1);
    repeat (100) @(negedge clk);
    wr(2'd0, 6'h30);
    hi = 0;
    for (int s = 0; s < 300; s++) begin @(negedge clk); hi += int'(pwm_a) + int'(pwm_b); end
    check("R10 stopped outputs low", hi, 0);

    for (int sel = 0; sel < 8; sel++) begin
      setup(sel, 1 << (CW - 6), 0, 0, 0, 1, 0);
      hi = 0;
      for (int s = 0; s < 2 * tval(sel); s++) begin @(negedge clk); hi += int'(pwm_a); end
      check($sformatf("R3 prescaler sel %0d", sel), hi, tval(sel));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule